// File: doc/BRIEF.md
# Quad-SPI Serial Clock Engine

This block produces the bit timing and chip-select sequencing for a quad-SPI flash master. It holds a 32-bit configuration word and a separate enable flag. From these it generates the serial clock. The clock runs at the reference clock divided by a power of two, and its idle level and sampling phase are selectable. The block drives an active-low chip-select vector and the strobes that a separate shift engine uses to move data: a word-start pulse, a per-bit completion pulse, launch and capture pulses that coincide with the serial clock edges, and a transfer-active flag.

A transfer starts in one of two ways. In automatic mode it starts as soon as the shift side reports queued data. In manual mode it waits for software to write a self-clearing start bit. At every word boundary the transfer continues with the next word if more data is queued, and ends otherwise. Software can hold the chip selects at a fixed pattern outside transfers. Clearing the enable stops everything immediately.

Top module: `qspi_clk_engine`

## Requirements
- R1: After reset the serial clock is 0, all chip selects are high, no transfer is active, no strobe is asserted, and the configuration and enable registers read 0.
- R2: The 3-bit divider exponent n sits in configuration bits [5:3]. Each serial clock half-period lasts 2^n reference cycles, so one bit takes 2<<n cycles. The first serial clock edge comes 2^n cycles after the transfer becomes active.
- R3: Configuration bit 1 sets the clock rest level. Whenever no transfer is active, the serial clock equals this bit.
- R4: Configuration bit 2 selects the phase. With 0, capture pulses come on the leading (away-from-rest) edge and launch pulses on the trailing edge. With 1, the two are swapped. Each pulse is one cycle long and appears in the same cycle as the clock change.
- R5: Bits [7:6] give the word length w, and each word carries 8*(w+1) bits. A bit-done pulse comes with every trailing edge, and a word-start pulse comes in the first active cycle of each word. If data is still queued at the end of a word, the next word follows without a gap; if not, the transfer ends.
- R6: Configuration bit 0 enables the master. With bit 15 clear, the master enabled, the controller enabled and data queued, a transfer starts on its own. With bit 0 clear, no transfer ever starts.
- R7: When bit 15 is set, a transfer starts only after a write with bit 16 set. Bit 16 reads 1 for one cycle and then returns to 0. A start that finds no queued data is dropped.
- R8: During a transfer the chip-select vector equals the select field at bits [10+:NCS] (active low). Outside a transfer all selects are high, unless bit 14 is set, in which case the field drives the selects at all times.
- R9: While the enable flag is 0, no transfer runs, the clock rests, and all chip selects are high. Clearing the flag mid-transfer aborts the transfer within two cycles.
- R10: The divider and word length are captured when a transfer starts. A divider write during a transfer does not change that transfer, but it applies to the next one.
- R11: The configuration reads back only its defined bits (0-7, 10..10+NCS-1, 14, 15, 16, 31). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 1 | Enable register write value |
| tx_pending | input | 1 | Shift side has queued transmit data |
| cfg_rdata | output | 32 | Configuration readback |
| sclk | output | 1 | Serial clock |
| cs_n | output | NCS | Active-low chip selects |
| xfer_active | output | 1 | Transfer in progress |
| word_start | output | 1 | First cycle of a word |
| bit_en | output | 1 | One bit completed (trailing edge) |
| launch | output | 1 | Data launch edge strobe |
| capture | output | 1 | Data capture edge strobe |

## Verification
A table of settings is run through single-word transfers. The settings combine all four word lengths, both polarities, both phases and divider exponents from 0 to 7. Cycle counts and the index of the first clock edge tell each divider exponent apart. Where the capture pulses fall relative to the clock level tells the two phases apart. Directed cases cover back-to-back words, a divider change during a transfer, an abort by disabling, manual start with and without queued data, a cleared master bit, and forced chip selects while idle and while disabled.

// File: rtl/qsce_pkg.sv
package qsce_pkg;
  localparam int DIV_W = 3;
  localparam int CNT_W = 2 ** DIV_W;
  localparam int BIT_W = 6;

  localparam int P_MASTER = 0;
  localparam int P_CPOL   = 1;
  localparam int P_CPHA   = 2;
  localparam int P_DIV    = 3;
  localparam int P_WID    = 6;
  localparam int P_SS     = 10;
  localparam int P_FORCE  = 14;
  localparam int P_MAN    = 15;
  localparam int P_GO     = 16;
  localparam int P_FLASH  = 31;

  typedef struct packed {
    logic             flash;
    logic             go;
    logic             man;
    logic             cs_force;
    logic [1:0]       wid;
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
    logic             master;
  } cfg_t;

  function automatic logic [31:0] cfg_mask(input int ncs);
    logic [31:0] m;
    m = 32'h0;
    for (int i = 0; i < 8; i++) m[i] = 1'b1;
    for (int i = 0; i < ncs; i++) m[P_SS+i] = 1'b1;
    m[P_FORCE] = 1'b1;
    m[P_MAN]   = 1'b1;
    m[P_GO]    = 1'b1;
    m[P_FLASH] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/qsce_cfg_regs.sv
module qsce_cfg_regs
  import qsce_pkg::*;
#(
  parameter int NCS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [31:0]    cfg_wdata,
  input  logic           en_we,
  input  logic           en_wdata,
  output cfg_t           cfg,
  output logic [NCS-1:0] ss,
  output logic           en,
  output logic [31:0]    rdata
);
  localparam logic [31:0] MASK = cfg_mask(NCS);

  logic [31:0] word_q;
  logic        en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (cfg_we) begin
      word_q <= cfg_wdata & MASK;
    end else begin
      word_q[P_GO] <= 1'b0;  // start request lives one cycle
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (en_we) en_q <= en_wdata;
  end

  always_comb begin
    cfg.flash    = word_q[P_FLASH];
    cfg.go       = word_q[P_GO];
    cfg.man      = word_q[P_MAN];
    cfg.cs_force = word_q[P_FORCE];
    cfg.wid      = word_q[P_WID +: 2];
    cfg.div      = word_q[P_DIV +: DIV_W];
    cfg.cpha     = word_q[P_CPHA];
    cfg.cpol     = word_q[P_CPOL];
    cfg.master   = word_q[P_MASTER];
  end

  assign ss    = word_q[P_SS +: NCS];
  assign en    = en_q;
  assign rdata = word_q;
endmodule

// File: rtl/qsce_prescaler.sv
module qsce_prescaler
  import qsce_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] exp_n,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = (CNT_W'(1) << exp_n) - CNT_W'(1);
  assign tick = !clear && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/qsce_seq.sv
module qsce_seq
  import qsce_pkg::*;
#(
  parameter int NCS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  cfg_t             cfg,
  input  logic [NCS-1:0]   ss,
  input  logic             tx_pending,
  input  logic             tick,
  output logic             pclear,
  output logic [DIV_W-1:0] div_lat,
  output logic             sclk,
  output logic [NCS-1:0]   cs_n,
  output logic             active,
  output logic             word_start,
  output logic             bit_en,
  output logic             launch,
  output logic             capture
);
  logic             active_q, half_q;
  logic [BIT_W-1:0] bit_q, wbits_q;
  logic [DIV_W-1:0] div_q;

  logic             nxt_active, nxt_half, lead, trail, wstart;
  logic [BIT_W-1:0] nxt_bit;
  logic             go_ok, last_bit;

  assign go_ok    = cfg.master && tx_pending && (cfg.man ? cfg.go : 1'b1);
  assign last_bit = (bit_q == wbits_q - BIT_W'(1));
  assign pclear   = !active_q || !en;
  assign div_lat  = div_q;

  always_comb begin
    nxt_active = active_q;
    nxt_half   = half_q;
    nxt_bit    = bit_q;
    lead       = 1'b0;
    trail      = 1'b0;
    wstart     = 1'b0;
    if (!en) begin
      nxt_active = 1'b0;
      nxt_half   = 1'b0;
      nxt_bit    = '0;
    end else if (!active_q) begin
      if (go_ok) begin
        nxt_active = 1'b1;
        nxt_half   = 1'b0;
        nxt_bit    = '0;
        wstart     = 1'b1;
      end
    end else if (tick) begin
      if (!half_q) begin
        nxt_half = 1'b1;
        lead     = 1'b1;
      end else begin
        nxt_half = 1'b0;
        trail    = 1'b1;
        if (last_bit) begin
          nxt_bit = '0;
          if (tx_pending) wstart = 1'b1;
          else            nxt_active = 1'b0;
        end else begin
          nxt_bit = bit_q + BIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      bit_q    <= '0;
      wbits_q  <= BIT_W'(8);
      div_q    <= '0;
    end else begin
      active_q <= nxt_active;
      half_q   <= nxt_half;
      bit_q    <= nxt_bit;
      if (en && !active_q && go_ok) begin
        div_q   <= cfg.div;
        wbits_q <= BIT_W'({cfg.wid, 3'b000}) + BIT_W'(8);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk       <= 1'b0;
      cs_n       <= '1;
      active     <= 1'b0;
      word_start <= 1'b0;
      bit_en     <= 1'b0;
      launch     <= 1'b0;
      capture    <= 1'b0;
    end else begin
      sclk       <= cfg.cpol ^ (nxt_active & nxt_half);
      active     <= nxt_active;
      word_start <= wstart;
      bit_en     <= trail;
      launch     <= cfg.cpha ? lead  : trail;
      capture    <= cfg.cpha ? trail : lead;
      if (!en)                            cs_n <= '1;
      else if (cfg.cs_force || nxt_active) cs_n <= ss;
      else                                cs_n <= '1;
    end
  end
endmodule

// File: rtl/qspi_clk_engine.sv
module qspi_clk_engine
  import qsce_pkg::*;
#(
  parameter int NCS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [31:0]    cfg_wdata,
  input  logic           en_we,
  input  logic           en_wdata,
  input  logic           tx_pending,
  output logic [31:0]    cfg_rdata,
  output logic           sclk,
  output logic [NCS-1:0] cs_n,
  output logic           xfer_active,
  output logic           word_start,
  output logic           bit_en,
  output logic           launch,
  output logic           capture
);
  cfg_t             cfg;
  logic [NCS-1:0]   ss;
  logic             en_q;
  logic             tick, pclear;
  logic [DIV_W-1:0] div_lat;

  qsce_cfg_regs #(.NCS(NCS)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .en_we(en_we), .en_wdata(en_wdata),
    .cfg(cfg), .ss(ss), .en(en_q), .rdata(cfg_rdata)
  );

  qsce_prescaler u_div (
    .clk(clk), .rst(rst), .clear(pclear), .exp_n(div_lat), .tick(tick)
  );

  qsce_seq #(.NCS(NCS)) u_seq (
    .clk(clk), .rst(rst), .en(en_q), .cfg(cfg), .ss(ss),
    .tx_pending(tx_pending), .tick(tick), .pclear(pclear), .div_lat(div_lat),
    .sclk(sclk), .cs_n(cs_n), .active(xfer_active), .word_start(word_start),
    .bit_en(bit_en), .launch(launch), .capture(capture)
  );
endmodule

// File: rtl/qsce_checker.sv
module qsce_checker #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           en_q,
  input logic           cfg_we,
  input logic [31:0]    cfg_rdata,
  input logic           sclk,
  input logic [NCS-1:0] cs_n,
  input logic           xfer_active,
  input logic           word_start,
  input logic           bit_en,
  input logic           launch,
  input logic           capture
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!xfer_active && cfg_rdata[1] == $past(cfg_rdata[1])) |-> sclk == cfg_rdata[1]); // R3

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({launch, capture})); // R4

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    word_start |-> xfer_active); // R5

  AST_BITEN_REST: assert property (@(posedge clk) disable iff (rst)
    (bit_en && $stable(cfg_rdata[1])) |-> sclk == cfg_rdata[1]); // R5

  AST_GO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[16] && !cfg_we) |=> !cfg_rdata[16]); // R7

  AST_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(!en_q) |-> (&cs_n)); // R9

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(!en_q) |-> !xfer_active); // R9
endmodule

bind qspi_clk_engine qsce_checker #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .sclk(sclk), .cs_n(cs_n), .xfer_active(xfer_active), .word_start(word_start),
  .bit_en(bit_en), .launch(launch), .capture(capture)
);

// File: tb/tb_qspi_clk_engine.sv
module tb_qspi_clk_engine;
  localparam int NCS = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_we = 1'b0;
  logic [31:0]    cfg_wdata = '0;
  logic           en_we = 1'b0;
  logic           en_wdata = 1'b0;
  logic           tx_pending = 1'b0;
  logic [31:0]    cfg_rdata;
  logic           sclk;
  logic [NCS-1:0] cs_n;
  logic           xfer_active, word_start, bit_en, launch, capture;

  int n_tests = 0;
  int n_fail  = 0;

  int m_cyc, m_bits, m_starts, m_capl, m_capt, m_flip, m_csbad;
  bit m_got, m_rest;

  always #2 clk = ~clk;  // 250 MHz

  qspi_clk_engine #(.NCS(NCS)) dut (.*);

  // packed vector: [31:20] cycles, [19:12] bits, [8:7] ss, [6:5] wid, [4] cpha, [3] cpol, [2:0] div
  localparam logic [31:0] VEC [6] = '{
    {12'd16,   8'd8,  3'd0, 2'b10, 2'd0, 1'b0, 1'b0, 3'd0},
    {12'd64,   8'd16, 3'd0, 2'b01, 2'd1, 1'b0, 1'b1, 3'd1},
    {12'd192,  8'd24, 3'd0, 2'b10, 2'd2, 1'b1, 1'b0, 3'd2},
    {12'd512,  8'd32, 3'd0, 2'b00, 2'd3, 1'b1, 1'b1, 3'd3},
    {12'd2048, 8'd8,  3'd0, 2'b01, 2'd0, 1'b0, 1'b0, 3'd7},
    {12'd512,  8'd8,  3'd0, 2'b10, 2'd0, 1'b1, 1'b1, 3'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] div, input bit cpol, input bit cpha,
                                     input logic [1:0] wid, input logic [1:0] ss, input bit frc,
                                     input bit man, input bit go, input bit mst);
    logic [31:0] v;
    v = '0;
    v[0] = mst; v[1] = cpol; v[2] = cpha; v[5:3] = div; v[7:6] = wid;
    v[11:10] = ss; v[14] = frc; v[15] = man; v[16] = go;
    return v;
  endfunction

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_en(input bit v);
    @(negedge clk); en_we = 1'b1; en_wdata = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic measure(input bit cpol, input logic [NCS-1:0] ss, input int hold,
                         input int chg_at, input logic [31:0] chg_val, input int dis_at);
    int  idx;
    bit  done;
    m_cyc = 0; m_bits = 0; m_starts = 0; m_capl = 0; m_capt = 0;
    m_flip = -1; m_csbad = 0; m_got = 1'b0; m_rest = 1'b0;
    @(negedge clk); tx_pending = 1'b1;
    for (int w = 0; w < 40 && !xfer_active; w++) @(negedge clk);
    if (!xfer_active) begin
      tx_pending = 1'b0;
      return;
    end
    m_got = 1'b1; idx = 0; done = 1'b0;
    while (!done) begin
      cfg_we = 1'b0; en_we = 1'b0;
      if (idx >= hold) tx_pending = 1'b0;
      if (idx == chg_at) begin cfg_we = 1'b1; cfg_wdata = chg_val; end
      if (idx == dis_at) begin en_we = 1'b1; en_wdata = 1'b0; end
      if (xfer_active) m_cyc++;
      if (xfer_active && m_flip < 0 && sclk != cpol) m_flip = idx;
      if (bit_en) m_bits++;
      if (word_start) m_starts++;
      if (capture) begin
        if (sclk != cpol) m_capl++;
        else              m_capt++;
      end
      if (xfer_active && cs_n != ss) m_csbad++;
      if (!xfer_active) begin
        done = 1'b1;
        m_rest = (sclk == cpol);
      end else begin
        idx++;
        if (idx > 20000) done = 1'b1;
        @(negedge clk);
      end
    end
    cfg_we = 1'b0; en_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 sclk", 32'(sclk), 32'd0);
    check("R1 cs_n", 32'(cs_n), 32'h3);
    check("R1 active", 32'({xfer_active, word_start, bit_en, launch, capture}), 32'd0);
    check("R1 cfg", cfg_rdata, 32'd0);

    // R11 readback mask, R7 self-clearing start bit
    wr_cfg(32'hFFFF_FFFF);
    check("R11 readback", cfg_rdata, 32'h8001_CCFF);
    @(negedge clk);
    check("R7 go clears", cfg_rdata, 32'h8000_CCFF);
    // R9 disabled with forced select: all high
    check("R9 cs while disabled", 32'(cs_n), 32'h3);

    wr_en(1'b1);
    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = VEC[i];
      wr_cfg(mk(v[2:0], v[3], v[4], v[6:5], v[8:7], 1'b0, 1'b0, 1'b0, 1'b1));
      measure(v[3], v[8:7], 0, -1, '0, -1);
      check("R5 word cycles", 32'(m_cyc), 32'(v[31:20]));
      check("R5 bit pulses", 32'(m_bits), 32'(v[19:12]));
      check("R5 one word start", 32'(m_starts), 32'd1);
      check("R2 first edge", 32'(m_flip), 32'd1 << v[2:0]);
      check("R4 capture placement", 32'(v[4] ? m_capt : m_capl), 32'(v[19:12]));
      check("R8 cs during xfer", 32'(m_csbad), 32'd0);
      check("R3 rest level", 32'(m_rest), 32'd1);
      check("R8 cs idle high", 32'(cs_n), 32'h3);
    end

    // R5 back-to-back words
    wr_cfg(mk(3'd0, 1'b0, 1'b0, 2'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1));
    measure(1'b0, 2'b10, 20, -1, '0, -1);
    check("R5 two words cycles", 32'(m_cyc), 32'd32);
    check("R5 two word starts", 32'(m_starts), 32'd2);

    // R10 divider change mid-transfer
    wr_cfg(mk(3'd2, 1'b0, 1'b0, 2'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1));
    measure(1'b0, 2'b10, 0, 10, mk(3'd0, 1'b0, 1'b0, 2'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1), -1);
    check("R10 latched divider", 32'(m_cyc), 32'd64);
    measure(1'b0, 2'b10, 0, -1, '0, -1);
    check("R10 new divider next xfer", 32'(m_cyc), 32'd16);

    // R9 abort by disable
    wr_cfg(mk(3'd3, 1'b1, 1'b0, 2'd3, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1));
    measure(1'b1, 2'b01, 0, -1, '0, 20);
    check("R9 abort cycles", 32'(m_cyc), 32'd22);
    check("R9 abort rest level", 32'(m_rest), 32'd1);
    check("R9 abort cs high", 32'(cs_n), 32'h3);
    wr_en(1'b1);

    // R6 master bit clear: no start
    wr_cfg(mk(3'd0, 1'b0, 1'b0, 2'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0));
    measure(1'b0, 2'b10, 0, -1, '0, -1);
    check("R6 no master no xfer", 32'(m_got), 32'd0);

    // R7 manual start waits for start bit
    wr_cfg(mk(3'd0, 1'b0, 1'b0, 2'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1));
    tx_pending = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 waits for start", 32'(xfer_active), 32'd0);
    cfg_we = 1'b1; cfg_wdata = mk(3'd0, 1'b0, 1'b0, 2'd0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); cfg_we = 1'b0;
    check("R7 start bit visible", 32'(cfg_rdata[16]), 32'd1);
    @(negedge clk);
    tx_pending = 1'b0;
    check("R7 start launches", 32'(xfer_active), 32'd1);
    check("R7 start bit cleared", 32'(cfg_rdata[16]), 32'd0);
    for (int w = 0; w < 40 && xfer_active; w++) @(negedge clk);
    // start with nothing queued is dropped
    wr_cfg(mk(3'd0, 1'b0, 1'b0, 2'd0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1));
    repeat (4) @(negedge clk);
    tx_pending = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 dropped start", 32'(xfer_active), 32'd0);
    tx_pending = 1'b0;

    // R8 forced select while idle, R9 disable overrides it
    wr_cfg(mk(3'd0, 1'b0, 1'b0, 2'd0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check("R8 forced cs idle", 32'(cs_n), 32'h1);
    wr_en(1'b0);
    @(negedge clk);
    check("R9 disable beats force", 32'(cs_n), 32'h3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule